// File: doc/BRIEF.md
# Shadow-Staged Precision Time Counter

This block keeps a free-running 96-bit time count. The count is split into a high nanosecond word, a low nanosecond word and a 32-bit sub-nanosecond fraction. Every clock cycle a programmable 40-bit increment is added to the count, so the fraction carries into the nanosecond words. A second 64-bit register, the port timer, follows the low nanosecond word and the fraction. Timestamp units elsewhere in the chip use it as their local time base.

Software never changes time, rate or offset directly. It writes new values into shadow registers and then arms an opcode in the command register. A separate one-cycle sync strobe commits the armed opcode. The commit updates the source count and the port timer on the same clock edge, so the two never disagree. The load-increment and adjust opcodes take their operands from the same adjustment shadow pair. The read opcode freezes a coherent copy of all 96 bits for readout.

Top module: `ptp_shadow_timer`

## Requirements
- R1: While reset is held, and right after it, the count and the port timer are zero, the error flag is low and the increment equals the `INC_RESET` parameter (default 40'h01_0000_0000, one nanosecond per cycle).
- R2: On each clock edge without a committed load-time, the increment (zero-extended) is added to the 96-bit count {time_hi, time_lo, time_frac}. The carry runs from the fraction into both nanosecond words.
- R3: A sync strobe with armed opcode 1 (load time) sets the count to {shadow high, shadow low, 32'h0} on that edge.
- R4: A sync strobe with armed opcode 2 (load increment) sets the increment to {adj_hi[7:0], adj_lo}. Bits [31:8] of adj_hi are ignored. The commit edge itself still adds the old increment, and the new one applies from the next edge.
- R5: A sync strobe with armed opcode 3 (adjust) adds the sign-extended adj_hi to the 64-bit nanosecond part on top of the normal increment. adj_lo has no effect on the fraction.
- R6: A sync strobe with armed opcode 4 (read) copies the count value from just before that edge into the three readback words. They hold that value until the next read commit.
- R7: Writing the command register only arms an opcode. Without a sync strobe, time and increment keep running unchanged.
- R8: The command register holds the opcode in bits [2:0] and a source select in bits [7:4]. Every sync strobe clears the opcode and keeps the select. A sync strobe with opcode 0 has no effect.
- R9: The count wraps modulo 2^96: all-ones nanoseconds plus one nanosecond gives zero.
- R10: Opcodes 5, 6 and 7 (5 is adjust-at-time) are unsupported. Committing one leaves the count to its normal tick and sets cmd_err. The next commit of opcode 1 to 4 clears cmd_err.
- R11: port_time equals {time_lo, time_frac} in every cycle, including after every command.
- R12: Register addresses are: 0 shadow ns high, 1 shadow ns low, 2 adj_lo, 3 adj_hi, 4 command, 5/6/7 readback high/low/fraction, 8/9 live increment low/high (read-only). Reads are combinational on reg_addr, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one increment per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| sync_exec | input | 1 | Commit strobe for the armed opcode |
| time_hi | output | 32 | Live count, high nanoseconds |
| time_lo | output | 32 | Live count, low nanoseconds |
| time_frac | output | 32 | Live count, sub-nanosecond fraction |
| port_time | output | 64 | Port timer view |
| cmd_err | output | 1 | Unsupported opcode committed |

## Verification
A corrupted increment or a lost carry shows on the time outputs at the very next edge. It then grows linearly, so a fixed number of cycles after any known load exposes it. A port timer that slips away from the source count differs from {time_lo, time_frac} in the same cycle. A stale or uncleared opcode shows up as a changed count, or as an opcode still readable at address 4, one cycle after a later sync. A wrong capture shows in the readback words, which must equal the count sampled just before the commit edge.

// File: rtl/ptp_shadow_timer.sv
module ptp_shadow_timer #(
  parameter int          ADDR_W    = 4,
  parameter logic [39:0] INC_RESET = 40'h01_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sync_exec,
  output logic [31:0]       time_hi,
  output logic [31:0]       time_lo,
  output logic [31:0]       time_frac,
  output logic [63:0]       port_time,
  output logic              cmd_err
);

  localparam logic [ADDR_W-1:0] A_SH_HI  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SH_LO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ADJ_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ADJ_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RD_HI  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_RD_LO  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_RD_FR  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_INC_LO = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_INC_HI = ADDR_W'(9);

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_LOAD_TIME = 3'd1,
    OP_LOAD_INC  = 3'd2,
    OP_ADJUST    = 3'd3,
    OP_READ      = 3'd4
  } op_e;

  logic [31:0] sh_hi, sh_lo, adj_lo, adj_hi;
  logic [3:0]  sel_q;
  logic [2:0]  op_q;
  logic [95:0] cnt_q, rd_q;
  logic [63:0] port_q;
  logic [39:0] inc_q;
  logic        err_q;

  logic do_load, do_inc, do_adj, do_read, do_bad, do_good;
  assign do_load = sync_exec && op_q == OP_LOAD_TIME;
  assign do_inc  = sync_exec && op_q == OP_LOAD_INC;
  assign do_adj  = sync_exec && op_q == OP_ADJUST;
  assign do_read = sync_exec && op_q == OP_READ;
  assign do_bad  = sync_exec && op_q > OP_READ;
  assign do_good = do_load || do_inc || do_adj || do_read;

  logic [95:0] cnt_tick;
  logic [63:0] port_tick;
  logic [63:0] adj_ns;
  assign cnt_tick  = cnt_q + {56'd0, inc_q};
  assign port_tick = port_q + {24'd0, inc_q};
  assign adj_ns    = {{32{adj_hi[31]}}, adj_hi};

  logic wr_cmd;
  assign wr_cmd = reg_wr && reg_addr == A_CMD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hi  <= '0;
      sh_lo  <= '0;
      adj_lo <= '0;
      adj_hi <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_SH_HI)  sh_hi  <= reg_wdata;
      if (reg_addr == A_SH_LO)  sh_lo  <= reg_wdata;
      if (reg_addr == A_ADJ_LO) adj_lo <= reg_wdata;
      if (reg_addr == A_ADJ_HI) adj_hi <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      op_q  <= OP_NONE;
    end else if (wr_cmd) begin
      sel_q <= reg_wdata[7:4];
      op_q  <= reg_wdata[2:0];
    end else if (sync_exec) begin
      op_q  <= OP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_load) begin
      cnt_q <= {sh_hi, sh_lo, 32'd0};
    end else if (do_adj) begin
      cnt_q <= cnt_tick + {adj_ns, 32'd0};
    end else begin
      cnt_q <= cnt_tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
    end else if (do_load) begin
      port_q <= {sh_lo, 32'd0};
    end else if (do_adj) begin
      port_q <= port_tick + {adj_hi, 32'd0};
    end else begin
      port_q <= port_tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= INC_RESET;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (do_inc)  inc_q <= {adj_hi[7:0], adj_lo};
      if (do_read) rd_q  <= cnt_q;
      if (do_bad)       err_q <= 1'b1;
      else if (do_good) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_SH_HI:  reg_rdata = sh_hi;
      A_SH_LO:  reg_rdata = sh_lo;
      A_ADJ_LO: reg_rdata = adj_lo;
      A_ADJ_HI: reg_rdata = adj_hi;
      A_CMD:    reg_rdata = {24'd0, sel_q, 1'b0, op_q};
      A_RD_HI:  reg_rdata = rd_q[95:64];
      A_RD_LO:  reg_rdata = rd_q[63:32];
      A_RD_FR:  reg_rdata = rd_q[31:0];
      A_INC_LO: reg_rdata = inc_q[31:0];
      A_INC_HI: reg_rdata = {24'd0, inc_q[39:32]};
      default:  reg_rdata = '0;
    endcase
  end

  assign time_hi   = cnt_q[95:64];
  assign time_lo   = cnt_q[63:32];
  assign time_frac = cnt_q[31:0];
  assign port_time = port_q;
  assign cmd_err   = err_q;

endmodule

module ptp_shadow_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        sync_exec,
  input logic [2:0]  op_q,
  input logic [31:0] sh_hi,
  input logic [31:0] sh_lo,
  input logic [31:0] time_hi,
  input logic [31:0] time_lo,
  input logic [31:0] time_frac,
  input logic [63:0] port_time,
  input logic [39:0] inc_q,
  input logic        cmd_err
);
  logic [95:0] cnt;
  assign cnt = {time_hi, time_lo, time_frac};

  AST_PORT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    port_time == cnt[63:0]); // R11
  AST_PLAIN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(sync_exec) |-> cnt == $past(cnt) + {56'd0, $past(inc_q)}); // R2
  AST_LOAD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    sync_exec && op_q == 3'd1 |=> cnt == {$past(sh_hi), $past(sh_lo), 32'd0}); // R3
  AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_exec && op_q == 3'd2) |=> $stable(inc_q)); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_exec && op_q >= 3'd5 |=> cmd_err); // R10
  AST_OP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_exec && !reg_wr |=> op_q == 3'd0); // R8
endmodule

bind ptp_shadow_timer ptp_shadow_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .sync_exec(sync_exec), .op_q(op_q),
  .sh_hi(sh_hi), .sh_lo(sh_lo), .time_hi(time_hi), .time_lo(time_lo),
  .time_frac(time_frac), .port_time(port_time), .inc_q(inc_q), .cmd_err(cmd_err)
);

// File: tb/test_ptp_shadow_timer.sv
module test_ptp_shadow_timer;
  localparam logic [39:0] INC0 = 40'h01_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sync_exec = 1'b0;
  logic [31:0] time_hi, time_lo, time_frac;
  logic [63:0] port_time;
  logic        cmd_err;

  always #10 clk = ~clk;

  ptp_shadow_timer i_ptp_shadow_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_exec(sync_exec),
    .time_hi(time_hi), .time_lo(time_lo), .time_frac(time_frac),
    .port_time(port_time), .cmd_err(cmd_err)
  );

  int errs = 0;
  int checks = 0;
  logic [39:0] cur_inc = INC0;

  function automatic logic [95:0] live();
    return {time_hi, time_lo, time_frac};
  endfunction

  task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_time(input string tag, input logic [95:0] exp);
    chk(tag, live(), exp);
    chk({tag, " R11 port"}, {32'd0, port_time}, {32'd0, exp[63:0]});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_sync(output logic [95:0] pre);
    @(negedge clk);
    pre = live();
    sync_exec = 1'b1;
    @(negedge clk);
    sync_exec = 1'b0;
  endtask

  function automatic logic [95:0] ticks(input int k, input logic [39:0] inc);
    return 96'(k) * {56'd0, inc};
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [95:0] pre, snap, exp;
    logic [31:0] d0, d1, d2;

    repeat (3) @(negedge clk);
    chk_time("R1 reset count", 96'd0);
    chk("R1 reset err", {95'd0, cmd_err}, 96'd0);
    rd(4'd8, d0); rd(4'd9, d1);
    chk("R1 reset inc", {56'd0, d1[7:0], d0}, {56'd0, INC0});
    rd(4'd0, d0);
    chk("R1 reset shadow", {64'd0, d0}, 96'd0);

    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_time("R2 free run", ticks(5, INC0));

    // R3 load time sweep, R9 wrap on the last entry
    for (int i = 0; i < 7; i++) begin
      logic [31:0] hv, lv;
      hv = (i == 6) ? 32'hFFFF_FFFF : ((32'h1 << (i * 5)) ^ 32'(i * 7));
      lv = (i == 6) ? 32'hFFFF_FFFF : (32'hFFFF_FFF0 - 32'(i * 3));
      wr(4'd0, hv);
      wr(4'd1, lv);
      wr(4'd4, 32'h1);
      do_sync(pre);
      chk_time("R3 load time", {hv, lv, 32'd0});
      @(negedge clk);
      chk_time("R2 R9 tick after load", {hv, lv, 32'd0} + ticks(1, cur_inc));
      repeat (2) @(negedge clk);
      chk_time("R2 tick x3", {hv, lv, 32'd0} + ticks(3, cur_inc));
    end

    // R7 armed only, R8 opcode clear and select kept
    wr(4'd0, 32'h1234_5678);
    wr(4'd1, 32'h9ABC_DEF0);
    wr(4'd4, 32'h0000_00A1);
    snap = live();
    repeat (4) @(negedge clk);
    chk_time("R7 armed no effect", snap + ticks(4, cur_inc));
    rd(4'd4, d0);
    chk("R7 cmd armed", {64'd0, d0}, {64'd0, 32'hA1});
    do_sync(pre);
    chk_time("R3 load after arm", {32'h1234_5678, 32'h9ABC_DEF0, 32'd0});
    rd(4'd4, d0);
    chk("R8 opcode cleared", {64'd0, d0}, {64'd0, 32'hA0});
    do_sync(pre);
    chk_time("R8 empty sync", pre + ticks(1, cur_inc));

    // R4 increment sweep, junk in adj_hi[31:8]
    for (int i = 0; i < 5; i++) begin
      logic [39:0] ni;
      case (i)
        0: ni = 40'h00_8000_0000;
        1: ni = 40'h03_4000_0001;
        2: ni = 40'hFF_FFFF_FFFF;
        3: ni = 40'h00_0000_0001;
        default: ni = INC0;
      endcase
      wr(4'd2, ni[31:0]);
      wr(4'd3, {24'hA5A5A5, ni[39:32]});
      wr(4'd4, 32'h2);
      do_sync(pre);
      exp = pre + ticks(1, cur_inc);
      chk_time("R4 commit uses old inc", exp);
      @(negedge clk);
      chk_time("R4 new inc applies", exp + ticks(1, ni));
      rd(4'd8, d0); rd(4'd9, d1);
      chk("R4 inc readback", {56'd0, d1[7:0], d0}, {56'd0, ni});
      cur_inc = ni;
    end

    // R5 adjust sweep, including a borrow across the ns words
    wr(4'd0, 32'h1); wr(4'd1, 32'h0); wr(4'd4, 32'h1);
    do_sync(pre);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] av;
      case (i)
        0: av = 32'hFFFF_FFFF;
        1: av = 32'd5;
        2: av = 32'hFFFF_FFFB;
        3: av = 32'h7FFF_FFFF;
        4: av = 32'h8000_0000;
        default: av = 32'd1000;
      endcase
      wr(4'd2, 32'hDEAD_BEEF);
      wr(4'd3, av);
      wr(4'd4, 32'h3);
      do_sync(pre);
      exp = pre + ticks(1, cur_inc) + {{32{av[31]}}, av, 32'd0};
      chk_time("R5 adjust", exp);
    end

    // R6 read capture
    for (int i = 0; i < 2; i++) begin
      wr(4'd4, 32'h4);
      do_sync(pre);
      repeat (2) @(negedge clk);
      rd(4'd5, d0); rd(4'd6, d1); rd(4'd7, d2);
      chk("R6 coherent capture", {d0, d1, d2}, pre);
    end

    // R10 unsupported opcodes
    for (int c = 5; c < 8; c++) begin
      wr(4'd4, 32'(c));
      do_sync(pre);
      chk_time("R10 unsupported no change", pre + ticks(1, cur_inc));
      chk("R10 err set", {95'd0, cmd_err}, 96'd1);
    end
    repeat (3) @(negedge clk);
    chk("R10 err sticky", {95'd0, cmd_err}, 96'd1);
    wr(4'd4, 32'h4);
    do_sync(pre);
    chk("R10 err cleared", {95'd0, cmd_err}, 96'd0);

    // R12 writes to read-only addresses ignored
    rd(4'd8, d0);
    wr(4'd8, 32'h5555_5555);
    rd(4'd8, d1);
    chk("R12 read-only inc", {64'd0, d1}, {64'd0, d0});
    rd(4'd12, d0);
    chk("R12 unmapped zero", {64'd0, d0}, 96'd0);

    summary();
  end
endmodule